// File: doc/BRIEF.md
# Float to Integer Converter

This block turns one IEEE 754 binary32 or binary64 operand into a signed two's complement integer of either 32 or 64 bits. Each request carries its own rounding direction: nearest-even, toward zero, toward positive infinity or toward negative infinity. The direction applies to that request only, and no mode state is held between requests. Along with the integer, the block reports three cause flags: invalid, overflow and inexact.

When the value cannot be represented in the chosen width, the result is replaced by the largest positive integer of that width, whatever the sign of the operand. This covers NaN, infinity and out-of-range finite values. The block accepts a request on any cycle in which `in_valid` is high. It returns the registered result and flags on the next cycle together with a one-cycle `out_done` strobe, so requests can arrive back to back.

Top module: `fti_convert`

## Requirements
- R1: A request is taken on every rising edge where `in_valid` is high, and `out_done` is high in the following cycle. `out_done` is low after any edge where `in_valid` was low, and in that case the result and flags keep their previous values.
- R2: `in_mode` selects the rounding for that request only: 2'b00 rounds to nearest with ties to even, 2'b01 rounds toward zero, 2'b10 rounds toward positive infinity and 2'b11 rounds toward negative infinity.
- R3: When `in_src_dbl` is 1 the whole of `in_operand` is a binary64 value. When it is 0, a binary32 value is taken from `in_operand[31:0]` and bits [63:32] have no effect.
- R4: When `in_dst_long` is 1 the result is a 64-bit two's complement integer. When it is 0 the result is a 32-bit two's complement integer in `out_result[31:0]` and `out_result[63:32]` is zero.
- R5: A NaN or infinite operand sets only `out_invalid` and gives 0x7FFFFFFF (word) or 0x7FFFFFFFFFFFFFFF (long).
- R6: A finite operand whose rounded value lies outside the destination range sets only `out_overflow` and gives the same largest positive value, even when the operand is negative.
- R7: `out_inexact` is set exactly when nonzero fraction bits are discarded and neither invalid nor overflow is raised. At most one of the three flags is ever set.
- R8: A negative operand that rounds to zero gives an all-zero result.
- R9: The most negative integer of each width (-2^31 for a word, -2^63 for a long) is produced without any flag when the operand equals it exactly.
- R10: Subnormal operands convert by their true value: 0 or ±1 depending on the rounding direction, with inexact set.
- R11: While `rst_n` is low, `out_done`, `out_result` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_src_dbl | input | 1 | 1: binary64 operand, 0: binary32 in low half |
| in_dst_long | input | 1 | 1: 64-bit result, 0: 32-bit result |
| in_mode | input | 2 | Rounding direction for this request |
| in_operand | input | 64 | Floating-point operand |
| out_done | output | 1 | Result valid strobe |
| out_result | output | 64 | Integer result |
| out_invalid | output | 1 | Invalid cause flag |
| out_overflow | output | 1 | Overflow cause flag |
| out_inexact | output | 1 | Inexact cause flag |

## Verification
The assertions assume that `in_src_dbl`, `in_dst_long`, `in_mode` and `in_operand` are known whenever `in_valid` is high. They also assume that the check for a special exponent uses the same operand half that the format select picks. The random stimulus draws every request field from a fixed-seed generator and never leaves a value undriven. Exponents are drawn mostly in a window around each destination's range edge, with separate draws for all-zero and all-one exponent fields. Random garbage is placed in the unused upper half of binary32 operands so that the format select is what decides which half is used.

// File: rtl/fti_pkg.sv
package fti_pkg;
    localparam int INT_W      = 64;
    localparam int WORD_W     = 32;
    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = 52;
    localparam int SGL_EXP_W  = 8;
    localparam int SGL_FRAC_W = 23;
    localparam int MANT_W     = DBL_FRAC_W + 1;
    localparam int EXP_W      = 13;
    localparam int FIX_W      = 2 * INT_W;
    localparam int SHAMT_W    = 7;
    localparam int DBL_BIAS   = (1 << (DBL_EXP_W - 1)) - 1;
    localparam int SGL_BIAS   = (1 << (SGL_EXP_W - 1)) - 1;
    localparam int SHIFT_BASE = INT_W - DBL_FRAC_W;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_UP      = 2'b10,
        RM_DOWN    = 2'b11
    } rmode_e;

    // value = mant * 2^(exp - DBL_FRAC_W)
    typedef struct packed {
        logic                     sign;
        logic                     special;
        logic signed [EXP_W-1:0]  exp;
        logic [MANT_W-1:0]        mant;
    } unpacked_t;

    typedef struct packed {
        logic [INT_W-1:0] ipart;
        logic             half;
        logic             sticky;
        logic             huge;
    } aligned_t;

    typedef struct packed {
        logic             done;
        logic [INT_W-1:0] result;
        logic             inv;
        logic             ovf;
        logic             inx;
    } out_state_t;
endpackage

// File: rtl/fti_unpack.sv
module fti_unpack
    import fti_pkg::*;
(
    input  logic             src_dbl,
    input  logic [INT_W-1:0] operand,
    output unpacked_t        unp
);
    localparam int SGL_PAD = DBL_FRAC_W - SGL_FRAC_W;

    logic [DBL_EXP_W-1:0]  dbl_ef;
    logic [SGL_EXP_W-1:0]  sgl_ef;

    always_comb begin
        dbl_ef = operand[INT_W-2 -: DBL_EXP_W];
        sgl_ef = operand[WORD_W-2 -: SGL_EXP_W];
        unp    = '0;
        if (src_dbl) begin
            unp.sign    = operand[INT_W-1];
            unp.special = &dbl_ef;
            if (dbl_ef == '0) begin
                unp.exp  = EXP_W'(1 - DBL_BIAS);
                unp.mant = {1'b0, operand[DBL_FRAC_W-1:0]};
            end else begin
                unp.exp  = $signed(EXP_W'(dbl_ef)) - EXP_W'(DBL_BIAS);
                unp.mant = {1'b1, operand[DBL_FRAC_W-1:0]};
            end
        end else begin
            unp.sign    = operand[WORD_W-1];
            unp.special = &sgl_ef;
            if (sgl_ef == '0) begin
                unp.exp  = EXP_W'(1 - SGL_BIAS);
                unp.mant = {1'b0, operand[SGL_FRAC_W-1:0], {SGL_PAD{1'b0}}};
            end else begin
                unp.exp  = $signed(EXP_W'(sgl_ef)) - EXP_W'(SGL_BIAS);
                unp.mant = {1'b1, operand[SGL_FRAC_W-1:0], {SGL_PAD{1'b0}}};
            end
        end
    end
endmodule

// File: rtl/fti_align.sv
module fti_align
    import fti_pkg::*;
(
    input  unpacked_t unp,
    output aligned_t  aln
);
    logic [FIX_W-1:0]        fixed;
    logic signed [EXP_W-1:0] sh;

    always_comb begin
        sh    = unp.exp + EXP_W'(SHIFT_BASE);
        fixed = '0;
        aln   = '0;
        if (unp.exp >= EXP_W'(INT_W)) begin
            aln.huge = 1'b1;
        end else if (unp.exp < -EXP_W'(1)) begin
            aln.sticky = |unp.mant;
        end else begin
            fixed      = {{(FIX_W-MANT_W){1'b0}}, unp.mant} << sh[SHAMT_W-1:0];
            aln.ipart  = fixed[FIX_W-1:INT_W];
            aln.half   = fixed[INT_W-1];
            aln.sticky = |fixed[INT_W-2:0];
        end
    end
endmodule

// File: rtl/fti_round.sv
module fti_round
    import fti_pkg::*;
(
    input  logic             sign,
    input  logic             special,
    input  aligned_t         aln,
    input  logic             dst_long,
    input  rmode_e           mode,
    output logic [INT_W-1:0] result,
    output logic             inv,
    output logic             ovf,
    output logic             inx
);
    localparam logic [INT_W-1:0] LONG_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] WORD_MAX = {{(INT_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};

    logic             frac_nz;
    logic             inc;
    logic [INT_W:0]   mag;
    logic [INT_W:0]   lim;
    logic             out_of_range;
    logic [INT_W-1:0] signed_val;

    always_comb begin
        frac_nz = aln.half | aln.sticky;
        unique case (mode)
            RM_NEAREST: inc = aln.half & (aln.sticky | aln.ipart[0]);
            RM_ZERO:    inc = 1'b0;
            RM_UP:      inc = ~sign & frac_nz;
            RM_DOWN:    inc = sign & frac_nz;
            default:    inc = 1'b0;
        endcase
        mag          = {1'b0, aln.ipart} + {{INT_W{1'b0}}, inc};
        lim          = (INT_W+1)'(1) << (dst_long ? INT_W-1 : WORD_W-1);
        out_of_range = aln.huge | (sign ? (mag > lim) : (mag >= lim));
        signed_val   = sign ? (~mag[INT_W-1:0] + 1'b1) : mag[INT_W-1:0];

        inv = special;
        ovf = ~special & out_of_range;
        inx = ~special & ~out_of_range & frac_nz;
        if (special || out_of_range)
            result = dst_long ? LONG_MAX : WORD_MAX;
        else if (dst_long)
            result = signed_val;
        else
            result = {{(INT_W-WORD_W){1'b0}}, signed_val[WORD_W-1:0]};
    end
endmodule

// File: rtl/fti_convert.sv
module fti_convert
    import fti_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_src_dbl,
    input  logic        in_dst_long,
    input  logic [1:0]  in_mode,
    input  logic [63:0] in_operand,
    output logic        out_done,
    output logic [63:0] out_result,
    output logic        out_invalid,
    output logic        out_overflow,
    output logic        out_inexact
);
    unpacked_t        unp;
    aligned_t         aln;
    logic [INT_W-1:0] conv_res;
    logic             conv_inv;
    logic             conv_ovf;
    logic             conv_inx;
    out_state_t       st_d;
    out_state_t       st_q;

    fti_unpack u_unpack (
        .src_dbl (in_src_dbl),
        .operand (in_operand),
        .unp     (unp)
    );

    fti_align u_align (
        .unp (unp),
        .aln (aln)
    );

    fti_round u_round (
        .sign     (unp.sign),
        .special  (unp.special),
        .aln      (aln),
        .dst_long (in_dst_long),
        .mode     (rmode_e'(in_mode)),
        .result   (conv_res),
        .inv      (conv_inv),
        .ovf      (conv_ovf),
        .inx      (conv_inx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = in_valid;
        if (in_valid) begin
            st_d.result = conv_res;
            st_d.inv    = conv_inv;
            st_d.ovf    = conv_ovf;
            st_d.inx    = conv_inx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_done     = st_q.done;
    assign out_result   = st_q.result;
    assign out_invalid  = st_q.inv;
    assign out_overflow = st_q.ovf;
    assign out_inexact  = st_q.inx;

    logic in_special;
    assign in_special = in_src_dbl ? (&in_operand[62:52]) : (&in_operand[30:23]);

    assert_done_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_done);
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_done && $stable(out_result)));
    assert_word_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_dst_long) |=> (out_result[63:32] == 32'h0));
    assert_special_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dst_long && in_special) |=>
        (out_invalid && out_result == 64'h7FFF_FFFF_FFFF_FFFF));
    assert_special_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_dst_long && in_special) |=>
        (out_invalid && out_result == 64'h0000_0000_7FFF_FFFF));
    assert_overflow_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_overflow) |->
        (out_result == 64'h7FFF_FFFF_FFFF_FFFF || out_result == 64'h0000_0000_7FFF_FFFF));
    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> $onehot0({out_invalid, out_overflow, out_inexact}));
endmodule

// File: tb/tb_fti_convert.sv
`timescale 1ns/1ps
module tb_fti_convert;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_src_dbl;
    logic        in_dst_long;
    logic [1:0]  in_mode;
    logic [63:0] in_operand;
    logic        out_done;
    logic [63:0] out_result;
    logic        out_invalid;
    logic        out_overflow;
    logic        out_inexact;

    int n_checks = 0;
    int n_fails  = 0;
    bit summary_done = 0;

    always #2.5 clk = ~clk;

    fti_convert dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src_dbl(in_src_dbl),
        .in_dst_long(in_dst_long), .in_mode(in_mode), .in_operand(in_operand),
        .out_done(out_done), .out_result(out_result), .out_invalid(out_invalid),
        .out_overflow(out_overflow), .out_inexact(out_inexact)
    );

    localparam logic [63:0] LMAX = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] WMAX = 64'h0000_0000_7FFF_FFFF;

    // Expected value from the requirements: flags are {invalid, overflow, inexact}
    function automatic void ref_model(input logic [63:0] op, input logic dbl, input logic lng,
                                      input logic [1:0] md, output logic [63:0] res,
                                      output logic [2:0] fl);
        logic sgn, huge, up;
        int ef, fw, bias, e, s;
        logic [63:0] frac, mant, q, rem, hv, v;
        logic [64:0] q1, lim;
        if (dbl) begin
            sgn = op[63]; ef = int'(op[62:52]); frac = {12'b0, op[51:0]}; fw = 52; bias = 1023;
        end else begin
            sgn = op[31]; ef = int'(op[30:23]); frac = {41'b0, op[22:0]}; fw = 23; bias = 127;
        end
        if (ef == (dbl ? 2047 : 255)) begin
            res = lng ? LMAX : WMAX; fl = 3'b100; return;
        end
        mant = (ef != 0) ? (frac | (64'd1 << fw)) : frac;
        e = ((ef != 0) ? ef : 1) - bias - fw;
        huge = 0; q = 0; rem = 0; hv = 0;
        if (mant != 0) begin
            if (e >= 0) begin
                if (e + fw >= 64) huge = 1;
                else q = mant << e;
            end else begin
                s = -e;
                if (s >= 63) begin q = 0; rem = mant; hv = 64'h8000_0000_0000_0000; end
                else begin
                    q = mant >> s; rem = mant & ((64'd1 << s) - 1); hv = 64'd1 << (s - 1);
                end
            end
        end
        case (md)
            2'b00:   up = (rem != 0) && ((rem > hv) || (rem == hv && q[0]));
            2'b01:   up = 0;
            2'b10:   up = !sgn && rem != 0;
            default: up = sgn && rem != 0;
        endcase
        q1 = {1'b0, q} + {64'd0, up};
        lim = lng ? (sgn ? (65'd1 << 63) : (65'd1 << 63) - 1) : (sgn ? (65'd1 << 31) : (65'd1 << 31) - 1);
        if (huge || q1 > lim) begin
            res = lng ? LMAX : WMAX; fl = 3'b010;
        end else begin
            v = sgn ? (~q1[63:0] + 64'd1) : q1[63:0];
            res = lng ? v : {32'b0, v[31:0]};
            fl = {2'b00, rem != 0};
        end
    endfunction

    task automatic compare(input string tag, input logic done, input logic [63:0] r,
                           input logic [2:0] f, input logic [63:0] er, input logic [2:0] ef);
        n_checks++;
        if (done !== 1'b1 || r !== er || f !== ef) begin
            n_fails++;
            $display("FAIL %s: done=%0b result=%h flags=%b expected done=1 result=%h flags=%b",
                     tag, done, r, f, er, ef);
        end
    endtask

    task automatic issue(input logic [63:0] op, input logic dbl, input logic lng, input logic [1:0] md,
                         output logic d, output logic [63:0] r, output logic [2:0] f);
        @(negedge clk);
        in_operand = op; in_src_dbl = dbl; in_dst_long = lng; in_mode = md; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        d = out_done; r = out_result; f = {out_invalid, out_overflow, out_inexact};
    endtask

    task automatic directed(input string tag, input logic [63:0] op, input logic dbl, input logic lng,
                            input logic [1:0] md, input logic [63:0] er, input logic [2:0] ef);
        logic d; logic [63:0] r; logic [2:0] f;
        issue(op, dbl, lng, md, d, r, f);
        compare(tag, d, r, f, er, ef);
    endtask

    task automatic print_summary;
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++; n_fails++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
        print_summary();
        $finish;
    end

    initial begin
        logic d; logic [63:0] r, er, prev; logic [2:0] f, ef;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; in_src_dbl = 1'b0; in_dst_long = 1'b0;
        in_mode = 2'b00; in_operand = 64'h0;
        repeat (3) @(negedge clk);
        // R11 reset state
        n_checks++;
        if (out_done !== 1'b0 || out_result !== 64'h0 || {out_invalid, out_overflow, out_inexact} !== 3'b000) begin
            n_fails++;
            $display("FAIL R11: done=%b result=%h flags=%b expected 0/0/000", out_done, out_result,
                     {out_invalid, out_overflow, out_inexact});
        end
        rst_n = 1'b1;

        // R2 rounding directions
        directed("R2 nearest 2.5",   64'h4004_0000_0000_0000, 1, 1, 2'b00, 64'd2, 3'b001);
        directed("R2 nearest 3.5",   64'h400C_0000_0000_0000, 1, 1, 2'b00, 64'd4, 3'b001);
        directed("R2 nearest 0.5",   64'h3FE0_0000_0000_0000, 1, 1, 2'b00, 64'd0, 3'b001);
        directed("R2 up -2.5",       64'hC004_0000_0000_0000, 1, 1, 2'b10, 64'hFFFF_FFFF_FFFF_FFFE, 3'b001);
        directed("R2 down -2.5",     64'hC004_0000_0000_0000, 1, 1, 2'b11, 64'hFFFF_FFFF_FFFF_FFFD, 3'b001);
        directed("R2 zero -1.5",     64'hBFF8_0000_0000_0000, 1, 1, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 3'b001);
        // R3 single with garbage upper half
        directed("R3 single 1.5",    64'hDEAD_BEEF_3FC0_0000, 0, 1, 2'b00, 64'd2, 3'b001);
        // R4 word result
        directed("R4 word -1.5",     64'hBFF8_0000_0000_0000, 1, 0, 2'b01, 64'h0000_0000_FFFF_FFFF, 3'b001);
        // R5 specials
        directed("R5 NaN long",      64'h7FF8_0000_0000_0000, 1, 1, 2'b00, LMAX, 3'b100);
        directed("R5 -inf word",     64'hFFF0_0000_0000_0000, 1, 0, 2'b11, WMAX, 3'b100);
        directed("R5 single +inf",   64'h0000_0000_7F80_0000, 0, 1, 2'b01, LMAX, 3'b100);
        // R6 overflow
        directed("R6 2^31 word",     64'h41E0_0000_0000_0000, 1, 0, 2'b01, WMAX, 3'b010);
        directed("R6 -2^40 word",    64'hC270_0000_0000_0000, 1, 0, 2'b01, WMAX, 3'b010);
        directed("R6 2^63 long",     64'h43E0_0000_0000_0000, 1, 1, 2'b00, LMAX, 3'b010);
        // R8 negative to zero
        directed("R8 up -0.3",       64'hBFD3_3333_3333_3333, 1, 1, 2'b10, 64'd0, 3'b001);
        directed("R8 zero -0.3 word", 64'hBFD3_3333_3333_3333, 1, 0, 2'b01, 64'd0, 3'b001);
        // R9 most negative exact
        directed("R9 -2^31 word",    64'hC1E0_0000_0000_0000, 1, 0, 2'b00, 64'h0000_0000_8000_0000, 3'b000);
        directed("R9 -2^63 long",    64'hC3E0_0000_0000_0000, 1, 1, 2'b01, 64'h8000_0000_0000_0000, 3'b000);
        // R10 subnormals
        directed("R10 up subnormal",   64'h0000_0000_0000_0001, 1, 1, 2'b10, 64'd1, 3'b001);
        directed("R10 down subnormal", 64'h8000_0000_0000_0001, 1, 1, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 3'b001);
        directed("R10 zero subnormal", 64'h8000_0000_0000_0001, 1, 0, 2'b01, 64'd0, 3'b001);

        // R1 idle cycles: done low, result held
        prev = out_result;
        @(negedge clk);
        @(negedge clk);
        n_checks++;
        if (out_done !== 1'b0 || out_result !== prev) begin
            n_fails++;
            $display("FAIL R1: done=%b result=%h expected done=0 result=%h", out_done, out_result, prev);
        end

        // Random mix: R2 R3 R4 R6 R7
        for (int i = 0; i < 4000; i++) begin
            logic dbl, lng, sg; logic [1:0] md; logic [63:0] op; int sel, ex;
            dbl = 1'($urandom); lng = 1'($urandom); md = 2'($urandom); sg = 1'($urandom);
            sel = int'($urandom % 16);
            if (dbl) begin
                ex = (sel == 0) ? 2047 : (sel == 1) ? 0 : 1023 + int'($urandom % 80) - 10;
                op = {sg, 11'(ex), 20'($urandom), 32'($urandom)};
            end else begin
                ex = (sel == 0) ? 255 : (sel == 1) ? 0 : 127 + int'($urandom % 80) - 10;
                op = {32'($urandom), sg, 8'(ex), 23'($urandom)};
            end
            ref_model(op, dbl, lng, md, er, ef);
            issue(op, dbl, lng, md, d, r, f);
            compare("R7 random", d, r, f, er, ef);
        end

        print_summary();
        $finish;
    end
endmodule